// File: doc/BRIEF.md
# Scan-Driven Configuration Store Controller

This block executes instructions for a test access port on a device whose configuration lives in a small nonvolatile store. A separate TAP controller supplies the instruction code and one-cycle strobes for capture, shift, update and run-test-idle. This block decides what each strobe does to its scan registers and to the store.

The scan registers are an address register, a column data register, a 32-bit user signature register and a one-bit bypass register. The store holds a number of configuration columns, a saved signature and a DONE bit. Access to the store is allowed only in programming mode. A verify can step the address forward, so a scan host can read the store column by column. A ready-to-read flag must be set again by a discharge step after any write. The block also drives pin control outputs (high impedance, clamp) and a user-logic reset.

The update strobe and the run-test-idle strobe both execute the instruction. The instruction code is held stable while its strobes arrive.

Top module: `jtag_cfg_ctrl`

## Requirements
- R1: After synchronous reset, done, prog_mode and func_enable are 0, every store column is 0, and with the bypass code selected tdo reads 0.
- R2: With code 0x05 (verify) in programming mode and the ready flag set, capture copies the store column selected by the address register into the column register. The column register then shifts out least significant bit first on tdo.
- R3: Code 0x06 (verify with increment) captures like R2. An execute strobe (update or run-test-idle) in programming mode then adds one to the address. The address wraps from COLS-1 to 0.
- R4: Outside programming mode, codes 0x04, 0x05, 0x06, 0x08, 0x0E and 0x0F have no effect on the store, the saved signature, done, the address register or the column register contents.
- R5: Code 0x08 writes the signature register into the saved signature on execute. Code 0x09 loads the saved signature into the 32-bit signature register on capture and selects that register as the shift path.
- R6: Code 0x0A drives pins_hiz high. Codes 0x0B and 0x0C both drive pins_clamp high, with identical behaviour. The two outputs are never high together.
- R7: user_logic_rst is high while code 0x0D is selected or while reset_pin is high.
- R8: Code 0x0F sets done and code 0x0E clears it, leaving store columns unchanged. func_enable is high only when done is 1 and prog_mode is 0.
- R9: Any executed write (0x04, 0x08, 0x0E, 0x0F) clears the ready flag. A verify capture while it is clear loads all ones. Executing 0x07 (discharge) sets it again.
- R10: Any code not listed in R2 to R12 selects a one-bit bypass register. It captures 0 and delays tdi by one shift.
- R11: Execute of code 0x02 enters programming mode and code 0x03 leaves it. Code 0x04 writes the column register into the store at the current address on execute.
- R12: Code 0x01 places the address register itself in the shift path. After ADDR_W shifts, it holds the shifted-in value and has shifted out its old value LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 5 | Current instruction code |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe (execute) |
| run_idle | input | 1 | Run-test-idle strobe (execute) |
| tdi | input | 1 | Serial data in |
| reset_pin | input | 1 | External user-logic reset request |
| tdo | output | 1 | Serial data out, LSB of the selected register |
| done | output | 1 | Stored DONE bit |
| func_enable | output | 1 | Normal operation allowed |
| prog_mode | output | 1 | Programming mode active |
| user_logic_rst | output | 1 | Reset to user logic |
| pins_hiz | output | 1 | Put all outputs in high impedance |
| pins_clamp | output | 1 | Drive pins from boundary-scan contents |

## Verification
The hardest case to reach is a verify that returns real store data right after a stream of writes. The ready flag is then clear, so the first read must return all ones, and only a discharge restores true data. The stimulus programs several columns, some through update and some through run-test-idle, reads one before discharging and again after. It then walks verify-with-increment across the top column so the address wraps to zero. The gating is shown by first running every store instruction outside programming mode and then reading back the unchanged column register, address and store.

// File: rtl/jcfg_pkg.sv
package jcfg_pkg;

    localparam int INSTR_W = 5;
    localparam int UES_W   = 32;

    typedef enum logic [INSTR_W-1:0] {
        OP_ADDR       = 5'h01,
        OP_PM_ENTER   = 5'h02,
        OP_PM_EXIT    = 5'h03,
        OP_WR_COL     = 5'h04,
        OP_VERIFY     = 5'h05,
        OP_VERIFY_INC = 5'h06,
        OP_DISCHARGE  = 5'h07,
        OP_WR_UES     = 5'h08,
        OP_RD_UES     = 5'h09,
        OP_HIGHZ      = 5'h0A,
        OP_CLAMP      = 5'h0B,
        OP_NOOP       = 5'h0C,
        OP_ULRESET    = 5'h0D,
        OP_CLR_DONE   = 5'h0E,
        OP_SET_DONE   = 5'h0F,
        OP_BYPASS     = 5'h1F
    } op_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_ADDR,
        PATH_COL,
        PATH_UES
    } path_e;

    typedef struct packed {
        path_e path;
        logic  cap_col;
        logic  cap_ues;
        logic  inc_addr;
    } scan_ctl_t;

    typedef struct packed {
        logic wr_col;
        logic wr_ues;
        logic set_done;
        logic clr_done;
        logic discharge;
        logic pm_enter;
        logic pm_exit;
    } mem_ctl_t;

    typedef struct packed {
        logic hiz;
        logic clamp;
        logic ulr;
    } pin_ctl_t;

    function automatic scan_ctl_t scan_decode(input logic [INSTR_W-1:0] code);
        scan_ctl_t s;
        s = '{path: PATH_BYPASS, cap_col: 1'b0, cap_ues: 1'b0, inc_addr: 1'b0};
        case (code)
            OP_ADDR:       s.path = PATH_ADDR;
            OP_WR_COL:     s.path = PATH_COL;
            OP_VERIFY:     begin s.path = PATH_COL; s.cap_col = 1'b1; end
            OP_VERIFY_INC: begin s.path = PATH_COL; s.cap_col = 1'b1; s.inc_addr = 1'b1; end
            OP_WR_UES:     s.path = PATH_UES;
            OP_RD_UES:     begin s.path = PATH_UES; s.cap_ues = 1'b1; end
            default:       s.path = PATH_BYPASS;
        endcase
        return s;
    endfunction

    function automatic mem_ctl_t mem_decode(input logic [INSTR_W-1:0] code);
        mem_ctl_t m;
        m = '0;
        case (code)
            OP_WR_COL:    m.wr_col    = 1'b1;
            OP_WR_UES:    m.wr_ues    = 1'b1;
            OP_SET_DONE:  m.set_done  = 1'b1;
            OP_CLR_DONE:  m.clr_done  = 1'b1;
            OP_DISCHARGE: m.discharge = 1'b1;
            OP_PM_ENTER:  m.pm_enter  = 1'b1;
            OP_PM_EXIT:   m.pm_exit   = 1'b1;
            default:      m = '0;
        endcase
        return m;
    endfunction

    function automatic pin_ctl_t pin_decode(input logic [INSTR_W-1:0] code);
        pin_ctl_t p;
        p = '0;
        case (code)
            OP_HIGHZ:          p.hiz   = 1'b1;
            OP_CLAMP, OP_NOOP: p.clamp = 1'b1;
            OP_ULRESET:        p.ulr   = 1'b1;
            default:           p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/jcfg_decode.sv
module jcfg_decode
    import jcfg_pkg::*;
(
    input  logic [INSTR_W-1:0] code,
    output scan_ctl_t          sc,
    output mem_ctl_t           mc,
    output pin_ctl_t           pc
);
    always_comb begin
        sc = scan_decode(code);
        mc = mem_decode(code);
        pc = pin_decode(code);
    end
endmodule

// File: rtl/jcfg_store.sv
module jcfg_store
    import jcfg_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int COL_W  = 16,
    parameter int ADDR_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  mem_ctl_t          mc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [COL_W-1:0]  col_in,
    input  logic [UES_W-1:0]  ues_in,
    output logic [COL_W-1:0]  rd_col,
    output logic [UES_W-1:0]  ues_saved,
    output logic              done,
    output logic              prog_mode,
    output logic              ready
);
    logic [COL_W-1:0] mem_q [COLS];
    logic             any_write;

    assign any_write = mc.wr_col | mc.wr_ues | mc.set_done | mc.clr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COLS; i++) mem_q[i] <= '0;
            ues_saved <= '0;
            done      <= 1'b0;
            prog_mode <= 1'b0;
            ready     <= 1'b1;
        end else if (exec) begin
            if (mc.pm_enter)  prog_mode <= 1'b1;
            if (mc.pm_exit)   prog_mode <= 1'b0;
            if (mc.discharge) ready     <= 1'b1;
            if (prog_mode) begin
                if (mc.wr_col)   mem_q[addr] <= col_in;
                if (mc.wr_ues)   ues_saved   <= ues_in;
                if (mc.set_done) done        <= 1'b1;
                if (mc.clr_done) done        <= 1'b0;
                if (any_write)   ready       <= 1'b0;
            end
        end
    end

    assign rd_col = mem_q[addr];
endmodule

// File: rtl/jcfg_scan.sv
module jcfg_scan
    import jcfg_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int COL_W  = 16,
    parameter int ADDR_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              shift,
    input  logic              exec,
    input  scan_ctl_t         sc,
    input  logic              prog_mode,
    input  logic              ready,
    input  logic              tdi,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [UES_W-1:0]  ues_saved,
    output logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col,
    output logic [UES_W-1:0]  ues,
    output logic              tdo
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(COLS - 1);

    logic byp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            col   <= '0;
            ues   <= '0;
            byp_q <= 1'b0;
        end else if (capture) begin
            if (sc.cap_col && prog_mode) col <= ready ? rd_col : '1;
            if (sc.cap_ues)              ues <= ues_saved;
            if (sc.path == PATH_BYPASS)  byp_q <= 1'b0;
        end else if (shift) begin
            case (sc.path)
                PATH_ADDR: addr  <= {tdi, addr[ADDR_W-1:1]};
                PATH_COL:  col   <= {tdi, col[COL_W-1:1]};
                PATH_UES:  ues   <= {tdi, ues[UES_W-1:1]};
                default:   byp_q <= tdi;
            endcase
        end else if (exec && sc.inc_addr && prog_mode) begin
            addr <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
        end
    end

    always_comb begin
        case (sc.path)
            PATH_ADDR: tdo = addr[0];
            PATH_COL:  tdo = col[0];
            PATH_UES:  tdo = ues[0];
            default:   tdo = byp_q;
        endcase
    end
endmodule

// File: rtl/jtag_cfg_ctrl.sv
module jtag_cfg_ctrl
    import jcfg_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int COL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               run_idle,
    input  logic               tdi,
    input  logic               reset_pin,
    output logic               tdo,
    output logic               done,
    output logic               func_enable,
    output logic               prog_mode,
    output logic               user_logic_rst,
    output logic               pins_hiz,
    output logic               pins_clamp
);
    localparam int ADDR_W = $clog2(COLS);

    scan_ctl_t         sc;
    mem_ctl_t          mc;
    pin_ctl_t          pc;
    logic              exec;
    logic              ready_q;
    logic [ADDR_W-1:0] addr_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  rd_col;
    logic [UES_W-1:0]  ues_q;
    logic [UES_W-1:0]  ues_saved;

    assign exec = update_dr | run_idle;

    jcfg_decode u_dec (
        .code (instr),
        .sc   (sc),
        .mc   (mc),
        .pc   (pc)
    );

    jcfg_store #(.COLS(COLS), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .exec      (exec),
        .mc        (mc),
        .addr      (addr_q),
        .col_in    (col_q),
        .ues_in    (ues_q),
        .rd_col    (rd_col),
        .ues_saved (ues_saved),
        .done      (done),
        .prog_mode (prog_mode),
        .ready     (ready_q)
    );

    jcfg_scan #(.COLS(COLS), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture_dr),
        .shift     (shift_dr),
        .exec      (exec),
        .sc        (sc),
        .prog_mode (prog_mode),
        .ready     (ready_q),
        .tdi       (tdi),
        .rd_col    (rd_col),
        .ues_saved (ues_saved),
        .addr      (addr_q),
        .col       (col_q),
        .ues       (ues_q),
        .tdo       (tdo)
    );

    assign func_enable    = done & ~prog_mode;
    assign user_logic_rst = reset_pin | pc.ulr;
    assign pins_hiz       = pc.hiz;
    assign pins_clamp     = pc.clamp;
endmodule

// File: rtl/jtag_cfg_ctrl_chk.sv
module jtag_cfg_ctrl_chk
    import jcfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               run_idle,
    input logic               done,
    input logic               prog_mode,
    input logic               pins_hiz,
    input logic               pins_clamp,
    input logic               user_logic_rst,
    input logic [ADDR_W-1:0]  addr,
    input logic               ready
);
    assert_gate_done_R4: assert property (@(posedge clk) disable iff (rst)
        !prog_mode |=> $stable(done));

    assert_done_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> prog_mode);

    assert_ready_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(instr) == OP_DISCHARGE));

    assert_addr_move_R3: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |->
            (($past(shift_dr) && $past(instr) == OP_ADDR) ||
             ($past(update_dr || run_idle) && $past(instr) == OP_VERIFY_INC && $past(prog_mode))));

    assert_pins_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(pins_hiz && pins_clamp));

    assert_ulr_code_R7: assert property (@(posedge clk) disable iff (rst)
        (instr == OP_ULRESET) |-> user_logic_rst);
endmodule

bind jtag_cfg_ctrl jtag_cfg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .instr          (instr),
    .shift_dr       (shift_dr),
    .update_dr      (update_dr),
    .run_idle       (run_idle),
    .done           (done),
    .prog_mode      (prog_mode),
    .pins_hiz       (pins_hiz),
    .pins_clamp     (pins_clamp),
    .user_logic_rst (user_logic_rst),
    .addr           (addr_q),
    .ready          (ready_q)
);

// File: tb/jtag_cfg_ctrl_tb.sv
module jtag_cfg_ctrl_tb;
    import jcfg_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] instr = OP_BYPASS;
    logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, run_idle = 1'b0;
    logic       tdi = 1'b0, reset_pin = 1'b0;
    logic       tdo, done, func_enable, prog_mode, user_logic_rst, pins_hiz, pins_clamp;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    jtag_cfg_ctrl u_dut (
        .clk(clk), .rst(rst), .instr(instr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .run_idle(run_idle),
        .tdi(tdi), .reset_pin(reset_pin), .tdo(tdo), .done(done),
        .func_enable(func_enable), .prog_mode(prog_mode),
        .user_logic_rst(user_logic_rst), .pins_hiz(pins_hiz), .pins_clamp(pins_clamp)
    );

    // {code, hiz, clamp, ulr}
    localparam logic [7:0] PIN_TAB [7] = '{
        {5'h0A, 3'b100}, {5'h0B, 3'b010}, {5'h0C, 3'b010}, {5'h0D, 3'b001},
        {5'h1F, 3'b000}, {5'h13, 3'b000}, {5'h05, 3'b000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ins(input logic [4:0] c);
        @(negedge clk); instr = c;
    endtask

    task automatic cap();
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
    endtask

    task automatic upd();
        @(negedge clk); update_dr = 1'b1;
        @(negedge clk); update_dr = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk); run_idle = 1'b1;
        @(negedge clk); run_idle = 1'b0;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dout[i]  = tdo;
            tdi      = din[i];
            shift_dr = 1'b1;
        end
        @(negedge clk); shift_dr = 1'b0;
    endtask

    task automatic write_addr(input logic [2:0] a);
        logic [31:0] d;
        set_ins(OP_ADDR);
        shift_bits(3, {29'd0, a}, d);
    endtask

    task automatic prog_col(input logic [2:0] a, input logic [15:0] v, input bit use_idle);
        logic [31:0] d;
        write_addr(a);
        set_ins(OP_WR_COL);
        shift_bits(16, {16'd0, v}, d);
        if (use_idle) idle(); else upd();
    endtask

    task automatic read_col(input logic [2:0] a, output logic [15:0] v);
        logic [31:0] d;
        write_addr(a);
        set_ins(OP_VERIFY);
        cap();
        shift_bits(16, 32'd0, d);
        v = d[15:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 done/prog/func", {29'd0, done, prog_mode, func_enable}, 32'd0);
        chk("R1 tdo bypass", {31'd0, tdo}, 32'd0);

        // R6 R7 R10 pin decode table
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); instr = PIN_TAB[i][7:3]; #1;
            chk("R6/R7 pin table", {29'd0, pins_hiz, pins_clamp, user_logic_rst}, {29'd0, PIN_TAB[i][2:0]});
        end
        @(negedge clk); instr = OP_BYPASS; reset_pin = 1'b1; #1;
        chk("R7 reset pin", {31'd0, user_logic_rst}, 32'd1);
        @(negedge clk); reset_pin = 1'b0;

        // R10 unknown code bypass
        set_ins(5'h13);
        cap();
        shift_bits(4, 32'b1011, d);
        chk("R10 bypass delay", d, 32'b0110);

        // R4 gating outside programming mode
        set_ins(OP_SET_DONE); upd(); #1;
        chk("R4 done gated", {31'd0, done}, 32'd0);
        prog_col(3'd2, 16'hA5A5, 1'b0);
        set_ins(OP_VERIFY); cap();
        shift_bits(16, 32'hA5A5, d);
        chk("R4 verify gated col unchanged", d, 32'h0000A5A5);
        set_ins(OP_VERIFY_INC); cap(); upd();
        set_ins(OP_ADDR);
        shift_bits(3, 32'd2, d);
        chk("R4 R12 addr unchanged", d, 32'd2);

        // R11 programming mode entry
        set_ins(OP_PM_ENTER); upd(); #1;
        chk("R11 prog_mode", {31'd0, prog_mode}, 32'd1);
        read_col(3'd2, v);
        chk("R4 store untouched", {16'd0, v}, 32'd0);

        // R11 R9 R2 program and verify
        prog_col(3'd0, 16'h1234, 1'b0);
        prog_col(3'd1, 16'hBEEF, 1'b0);
        prog_col(3'd7, 16'hC0DE, 1'b1);
        read_col(3'd1, v);
        chk("R9 not ready all ones", {16'd0, v}, 32'h0000FFFF);
        set_ins(OP_DISCHARGE); upd();
        read_col(3'd1, v);
        chk("R2 R11 verify data", {16'd0, v}, 32'h0000BEEF);

        // R3 verify with increment and wrap
        write_addr(3'd7);
        set_ins(OP_VERIFY_INC); cap();
        shift_bits(16, 32'd0, d);
        chk("R3 col 7", d, 32'h0000C0DE);
        idle(); cap();
        shift_bits(16, 32'd0, d);
        chk("R3 wrap to col 0", d, 32'h00001234);
        upd();
        set_ins(OP_ADDR);
        shift_bits(3, 32'd5, d);
        chk("R3 R12 addr after two incs", d, 32'd1);

        // R8 done control
        set_ins(OP_SET_DONE); upd(); #1;
        chk("R8 done set", {30'd0, done, func_enable}, 32'b10);
        set_ins(OP_PM_EXIT); upd(); #1;
        chk("R8 func_enable", {31'd0, func_enable}, 32'd1);
        set_ins(OP_PM_ENTER); upd();
        set_ins(OP_CLR_DONE); upd(); #1;
        chk("R8 done cleared", {31'd0, done}, 32'd0);
        set_ins(OP_DISCHARGE); upd();
        read_col(3'd0, v);
        chk("R8 store intact", {16'd0, v}, 32'h00001234);

        // R5 signature write and read
        set_ins(OP_WR_UES);
        shift_bits(32, 32'hDEADBEEF, d);
        upd();
        set_ins(OP_RD_UES);
        shift_bits(32, 32'h0, d);
        cap();
        shift_bits(32, 32'h0, d);
        chk("R5 signature readback", d, 32'hDEADBEEF);

        // R4 signature write gated
        set_ins(OP_PM_EXIT); upd();
        set_ins(OP_WR_UES);
        shift_bits(32, 32'h12345678, d);
        upd();
        set_ins(OP_RD_UES); cap();
        shift_bits(32, 32'h0, d);
        chk("R4 signature gated", d, 32'hDEADBEEF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule